// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block buffers bytes coming from a fixed-rate serial source, such as a disk read channel, on their way to a CPU bus. The source cannot be stalled, so each byte is written on a one-cycle strobe. The CPU takes bytes out through a data read strobe and can read the current fill count at any time. A handler that has read the count knows how many bytes it may move without checking the queue before each one.

The interrupt is not raised for every byte. The request goes high when the fill count reaches a programmable threshold. The CPU then empties a whole block of bytes for each interrupt, and the slots still free above the threshold give it time to respond. A second mode raises the request as soon as the queue holds any byte. A byte that arrives while the queue is full is lost. The block records this loss in a sticky overrun flag, and that flag also drives the interrupt.

Top module: `rxq_thresh_irq`

## Requirements
- R1: The queue holds DEPTH bytes (16 by default). `fill_level` reports the number of bytes held and ranges from 0 to DEPTH. It changes one cycle after the strobe that changes it. After reset, `fill_level` is 0, `irq` is 0 and `overrun` is 0.
- R2: Bytes are returned in the order they were written. `rd_data` shows the popped byte from the cycle after the `rd_pop` strobe.
- R3: In threshold mode (`irq_any` = 0, `irq_thresh` from 1 to DEPTH), `irq` is 1 while `fill_level` >= `irq_thresh`. It returns to 0 in the cycle after a pop brings the count below the threshold, provided `overrun` is 0.
- R4: Not-empty mode applies when `irq_any` = 1 or when `irq_thresh` = 0. In this mode `irq` is 1 whenever `fill_level` >= 1, whatever threshold value is set.
- R5: A threshold value above DEPTH behaves as DEPTH. For example, a threshold of 20 raises `irq` only when the queue holds 16 bytes.
- R6: A write strobe while the queue is full and no pop is given drops the byte. `overrun` becomes 1 in the next cycle, `fill_level` stays at DEPTH, and the bytes already stored are unchanged.
- R7: `overrun` stays 1 until `ovr_clr` is pulsed. If a new overrun and `ovr_clr` occur in the same cycle, the new overrun wins and the flag stays set. While `overrun` is 1, `irq` is 1.
- R8: A write strobe and a pop strobe in the same cycle leave `fill_level` unchanged. When the queue was full, no overrun is flagged: the oldest byte is returned and the new byte is stored at the tail.
- R9: A pop strobe on an empty queue leaves `rd_data` at its last value and `fill_level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Source byte strobe |
| wr_byte | input | 8 | Source byte |
| rd_pop | input | 1 | CPU data-register read strobe |
| rd_data | output | 8 | Last popped byte |
| fill_level | output | 5 | Bytes currently held |
| irq_thresh | input | 5 | Interrupt fill threshold |
| irq_any | input | 1 | 1 selects not-empty interrupt mode |
| ovr_clr | input | 1 | Write-1-to-clear pulse for the overrun flag |
| overrun | output | 1 | Sticky lost-byte flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the full-queue boundary. A design that ignores fullness would overwrite the oldest byte. A design that misreads a simultaneous write and pop would either flag a false overrun or lose the new byte; the drained order after each case exposes both faults. The threshold edges are checked one byte below the threshold, at it, and above it after saturation, to catch an off-by-one comparison or a missing clamp. The tests also cover the zero-threshold alias, the same-cycle clear-versus-set race on the overrun flag, and a pop from an empty queue. The last of these would corrupt the read register or wrap the count.

// File: rtl/rxq_pkg.sv
// Package: shared helpers for the receive queue.
// Assumes: threshold and level use the same unsigned width.
package rxq_pkg;
    // Count width needed to hold 0..depth.
    function automatic int unsigned lvl_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Byte storage ring with registered read output.
// Assumes: wr_en and rd_en are already qualified against full and empty by the caller.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;

    // Pointer advance: natural wrap for a power-of-two depth, explicit wrap otherwise.
    generate
        if ((1 << PW) == DEPTH) begin : g_pow2
            assign wp_nxt = wp + 1'b1;
            assign rp_nxt = rp + 1'b1;
        end else begin : g_mod
            assign wp_nxt = (wp == LAST) ? '0 : wp + 1'b1;
            assign rp_nxt = (rp == LAST) ? '0 : rp + 1'b1;
        end
    endgenerate

    // Write the accepted byte into the ring.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    // Pointer and read-register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp      <= '0;
            rp      <= '0;
            rd_data <= '0;
        end else begin
            if (wr_en) wp <= wp_nxt;
            if (rd_en) begin
                rp      <= rp_nxt;
                rd_data <= mem[rp];
            end
        end
    end

    // R9: the read register holds its value when no pop is accepted.
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/rxq_count.sv
// Module: rxq_count
// Fill counter, strobe qualification and sticky overrun flag.
// Assumes: push and pop are single-cycle strobes from the source and the CPU.
module rxq_count #(
    parameter int DEPTH = 16,
    parameter int LW    = rxq_pkg::lvl_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          ovr_clr,
    output logic          wr_en,
    output logic          rd_en,
    output logic [LW-1:0] level,
    output logic          overrun
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic full, empty, lost;

    // Qualify strobes: a pop is accepted unless empty; a push fits if not full or a pop frees a slot.
    always_comb begin
        full  = (level == FULL_LVL);
        empty = (level == '0);
        rd_en = pop_req && !empty;
        wr_en = push_req && (!full || rd_en);
        lost  = push_req && !wr_en;
    end

    // Fill count update.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else if (wr_en && !rd_en) level <= level + 1'b1;
        else if (rd_en && !wr_en) level <= level - 1'b1;
    end

    // Sticky overrun: a new loss takes priority over a clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) overrun <= 1'b0;
        else if (lost) overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    assert_ovr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (overrun && level == FULL_LVL));
    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
    assert_pushpop_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && !empty) |=> $stable(level));
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> (level == '0));
endmodule

// File: rtl/rxq_thresh_irq.sv
// Module: rxq_thresh_irq (top)
// Receive byte queue that raises an interrupt on a fill-level threshold or on not-empty.
// Assumes: irq_thresh and irq_any are quasi-static; irq is level-sensitive.
module rxq_thresh_irq #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int LW    = rxq_pkg::lvl_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] fill_level,
    input  logic [LW-1:0] irq_thresh,
    input  logic          irq_any,
    input  logic          ovr_clr,
    output logic          overrun,
    output logic          irq
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic          wr_en, rd_en;
    logic [LW-1:0] eff_thr;

    rxq_count #(.DEPTH(DEPTH), .LW(LW)) u_count (
        .clk(clk), .rst_n(rst_n), .push_req(wr_stb), .pop_req(rd_pop),
        .ovr_clr(ovr_clr), .wr_en(wr_en), .rd_en(rd_en),
        .level(fill_level), .overrun(overrun)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_byte),
        .rd_en(rd_en), .rd_data(rd_data)
    );

    // Effective threshold: not-empty alias for mode bit or zero, clamp to depth.
    always_comb begin
        if (irq_any || irq_thresh == '0) eff_thr = LW'(1);
        else if (irq_thresh > FULL_LVL)  eff_thr = FULL_LVL;
        else                             eff_thr = irq_thresh;
    end

    // Request line: fill threshold reached or a byte was lost.
    assign irq = overrun || (fill_level >= eff_thr);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && !overrun) |-> !irq);
    assert_ovr_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> irq);
    assert_any_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any && fill_level != '0) |-> irq);
    assert_full_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL_LVL) |-> irq);
endmodule

// File: tb/tb_rxq_thresh_irq.sv
module tb_rxq_thresh_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       rd_pop = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] fill_level;
    logic [4:0] irq_thresh = 5'd12;
    logic       irq_any = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       overrun;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rxq_thresh_irq dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .rd_pop(rd_pop), .rd_data(rd_data), .fill_level(fill_level),
        .irq_thresh(irq_thresh), .irq_any(irq_any), .ovr_clr(ovr_clr),
        .overrun(overrun), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); wr_stb = 1'b1; wr_byte = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0; b = rd_data;
    endtask

    task automatic fill(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) push(base + 8'(i));
    endtask

    task automatic drain_expect(input string req, input int n, input logic [7:0] base);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            pop(b);
            chk(req, "drain order", b, int'(base + 8'(i)));
        end
    endtask

    task automatic t_reset;
        chk("R1", "reset level", fill_level, 0);
        chk("R1", "reset irq", irq, 0);
        chk("R1", "reset overrun", overrun, 0);
    endtask

    task automatic t_threshold;
        logic [7:0] b;
        irq_thresh = 5'd12; irq_any = 1'b0;
        fill(11, 8'h10);
        chk("R1", "level after 11", fill_level, 11);
        chk("R3", "irq below thresh", irq, 0);
        push(8'h1B);
        chk("R3", "irq at thresh", irq, 1);
        pop(b);
        chk("R2", "first byte", b, 8'h10);
        chk("R3", "irq drops below thresh", irq, 0);
        drain_expect("R2", 11, 8'h11);
        chk("R1", "drained level", fill_level, 0);
    endtask

    task automatic t_any_mode;
        logic [7:0] b;
        irq_thresh = 5'd0; irq_any = 1'b0;
        push(8'h55);
        chk("R4", "thresh0 one byte irq", irq, 1);
        pop(b);
        chk("R4", "thresh0 empty irq", irq, 0);
        irq_thresh = 5'd12; irq_any = 1'b1;
        push(8'h66);
        chk("R4", "any-mode one byte irq", irq, 1);
        pop(b);
        chk("R2", "any-mode byte", b, 8'h66);
        irq_any = 1'b0;
    endtask

    task automatic t_saturate;
        irq_thresh = 5'd20;
        fill(15, 8'h20);
        chk("R5", "sat thresh at 15", irq, 0);
        push(8'h2F);
        chk("R5", "sat thresh at 16", irq, 1);
        drain_expect("R2", 16, 8'h20);
        irq_thresh = 5'd12;
    endtask

    task automatic t_overrun;
        irq_thresh = 5'd20;
        fill(16, 8'h40);
        push(8'hEE);
        chk("R6", "overrun set", overrun, 1);
        chk("R6", "level stays full", fill_level, 16);
        chk("R7", "irq from overrun", irq, 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R7", "overrun cleared", overrun, 0);
        @(negedge clk); ovr_clr = 1'b1; wr_stb = 1'b1; wr_byte = 8'hED;
        @(negedge clk); ovr_clr = 1'b0; wr_stb = 1'b0;
        chk("R7", "set beats clear", overrun, 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        drain_expect("R6", 16, 8'h40);
        chk("R7", "no irq after clear and drain", irq, 0);
        irq_thresh = 5'd12;
    endtask

    task automatic t_pushpop_full;
        fill(16, 8'h70);
        @(negedge clk); wr_stb = 1'b1; wr_byte = 8'h99; rd_pop = 1'b1;
        @(negedge clk); wr_stb = 1'b0; rd_pop = 1'b0;
        chk("R8", "popped oldest", rd_data, 8'h70);
        chk("R8", "level unchanged", fill_level, 16);
        chk("R8", "no overrun", overrun, 0);
        drain_expect("R8", 15, 8'h71);
        drain_expect("R8", 1, 8'h99);
    endtask

    task automatic t_empty_pop;
        logic [7:0] b;
        pop(b);
        chk("R9", "empty pop data", b, 8'h99);
        chk("R9", "empty pop level", fill_level, 0);
        chk("R9", "empty pop overrun", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_threshold();
        t_any_mode();
        t_saturate();
        t_overrun();
        t_pushpop_full();
        t_empty_pop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule